// File: doc/BRIEF.md
# FIFO-Buffered I2C Master Engine

This block is an I2C bus master that software drives through a small register bank. Software writes the target address, a byte count, the transfer direction and a stop policy, loads outgoing bytes into a transmit FIFO, and sets a start bit. The engine then runs the START condition, the address byte with its read/write bit, and as many data bytes as the count asks for, all from one start command. A final STOP is issued, or the bus is left released so that the next message begins with a repeated START.

Received bytes collect in a receive FIFO that software pops through a data port. One interrupt line covers three events: transfer end, transmit level at or below a programmable low mark, and receive level at or above a programmable high mark. These let software refill or drain long messages while they run. Bus timing comes from an external quarter-bit strobe. Each bit takes four strobes, and SCL and SDA are driven open-drain.

Top module: `i2c_fifo_master`

## Requirements
- R1: After reset the bus outputs are released, the interrupt is low, and the status word reads busy (bit 0) = 0, transmit-empty (bit 3) = 1 and receive-full (bit 4) = 0.
- R2: A write to the control word (offset 0x00) that carries start (bit 0) = 1 and enable (bit 2) = 1 while not busy begins a transfer. The first byte on the bus is the address register (offset 0x04) bits 7:1 followed by R/W = direction (bit 3, 1 = read). A start write is ignored while busy or when enable is 0.
- R3: In a write, exactly count (offset 0x08) bytes are taken from the transmit FIFO (pushed through offset 0x10) and sent MSB first.
- R4: In a read, count bytes go into the receive FIFO, which is popped by reading offset 0x0C. The master ACKs every byte except the last and NACKs the last.
- R5: With stop-suppress (control bit 20) clear, the transfer ends with a STOP. With it set, no STOP is sent and both lines are left released, so the next start produces a repeated START.
- R6: A NACK to the address or to a written byte ends the transfer at once with a STOP, sets status bit 1, and sends no further data bytes.
- R7: At transfer end, status bit 2 sets and busy falls. irq_o is high while status bit 2 and interrupt enable (control bit 1) are both set.
- R8: Writing 0 to status bit 1 or bit 2 (offset 0x14) clears it. Writing 1 leaves it unchanged.
- R9: With control bit 9 set, irq_o rises during a busy write once the transmit level is at or below control bits 15:12. With control bit 10 set, irq_o rises once the receive level is at or above a nonzero control bits 19:16.
- R10: Writing 1 to bit 0 of the flush register (offset 0x18) empties both FIFOs.
- R11: If the transmit FIFO is empty at a byte boundary of a write, the engine produces no further SCL pulses until a byte arrives, then continues.
- R12: If the receive FIFO is full when a read byte completes, the engine waits, with busy held, until space is freed. No byte is lost.
- R13: A count of 0 sends only the address byte and then ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops receive FIFO at 0x0C) |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tick_i | input | 1 | Quarter-bit timing strobe |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume that sda_i reflects the wired-AND of the engine's own drive and the target's drive. They also assume that register writes are single-cycle strobes, so a start write and a flush never coincide with another access. The bench keeps to this by resolving both lines from the engine's enables and a behavioural target that changes SDA only while SCL is low. It issues every register access as a one-cycle pulse between clock edges, and it generates the timing strobe at a fixed quarter-bit rate.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int OFF_W = 5;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 5'h00;
  localparam logic [OFF_W-1:0] OFF_TADDR = 5'h04;
  localparam logic [OFF_W-1:0] OFF_COUNT = 5'h08;
  localparam logic [OFF_W-1:0] OFF_RXD   = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_TXD   = 5'h10;
  localparam logic [OFF_W-1:0] OFF_STAT  = 5'h14;
  localparam logic [OFF_W-1:0] OFF_FLUSH = 5'h18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ABIT, ST_AACK, ST_DBIT, ST_DACK, ST_STOP, ST_RSET
  } eng_state_e;
endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             go_i,
  input  logic             rd_i,
  input  logic             hold_bus_i,
  input  logic [6:0]       addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_avail_i,
  output logic             tx_pop_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_push_o,
  input  logic             rx_space_i,
  input  logic             sda_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             nack_o,
  output logic             scl_low_o,
  output logic             sda_low_o
);
  eng_state_e       state_q;
  logic [1:0]       q_q;
  logic [2:0]       bitn_q;
  logic [7:0]       sh_q;
  logic [CNT_W-1:0] remain_q;
  logic             rd_q, hold_q;
  logic             in_ack, ack_ok, more, stall, step, adv;
  logic             scl_nx, sda_nx, keep_sda;

  assign in_ack = (state_q == ST_AACK) || (state_q == ST_DACK);
  // a read DACK sees the engine's own drive; only target ACKs count
  assign ack_ok = !((state_q == ST_AACK || !rd_q) && sda_i);
  assign more   = (remain_q != '0);

  always_comb begin
    stall = 1'b0;
    if (q_q == 2'd3) begin
      if (in_ack && !rd_q && ack_ok && more && !tx_avail_i) stall = 1'b1;
      if (state_q == ST_DBIT && rd_q && bitn_q == 3'd0 && !rx_space_i) stall = 1'b1;
    end
  end

  assign step = tick_i && !stall && (state_q != ST_IDLE);
  assign adv  = step && (q_q == 2'd3);

  assign tx_pop_o  = adv && in_ack && !rd_q && ack_ok && more;
  assign rx_push_o = adv && (state_q == ST_DBIT) && rd_q && (bitn_q == 3'd0);
  assign rx_data_o = {sh_q[6:0], sda_i};
  assign done_o    = adv && (state_q == ST_STOP || state_q == ST_RSET);
  assign nack_o    = adv && in_ack && !ack_ok;
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      q_q      <= '0;
      bitn_q   <= '0;
      sh_q     <= '0;
      remain_q <= '0;
      rd_q     <= 1'b0;
      hold_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (go_i) begin
        state_q  <= ST_START;
        q_q      <= '0;
        rd_q     <= rd_i;
        hold_q   <= hold_bus_i;
        remain_q <= count_i;
        sh_q     <= {addr_i, rd_i};
      end
    end else begin
      if (step) q_q <= q_q + 2'd1;
      if (adv) begin
        unique case (state_q)
          ST_START: begin
            state_q <= ST_ABIT;
            bitn_q  <= 3'd7;
          end
          ST_ABIT: begin
            sh_q <= {sh_q[6:0], 1'b0};
            if (bitn_q == 3'd0) state_q <= ST_AACK;
            else bitn_q <= bitn_q - 3'd1;
          end
          ST_AACK, ST_DACK: begin
            if (!ack_ok)      state_q <= ST_STOP;
            else if (!more)   state_q <= hold_q ? ST_RSET : ST_STOP;
            else begin
              state_q <= ST_DBIT;
              bitn_q  <= 3'd7;
              if (!rd_q) sh_q <= tx_data_i;
            end
          end
          ST_DBIT: begin
            sh_q <= rd_q ? {sh_q[6:0], sda_i} : {sh_q[6:0], 1'b0};
            if (bitn_q == 3'd0) begin
              state_q  <= ST_DACK;
              remain_q <= remain_q - 1'b1;
            end else begin
              bitn_q <= bitn_q - 3'd1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // line drive per quarter phase; SCL low during q0/q1 of each bit slot
  always_comb begin
    scl_nx = !q_q[1];
    sda_nx = 1'b0;
    unique case (state_q)
      ST_IDLE:  scl_nx = 1'b0;
      ST_START: begin scl_nx = 1'b0; sda_nx = q_q[1]; end
      ST_ABIT:  sda_nx = !sh_q[7];
      ST_DBIT:  sda_nx = !rd_q && !sh_q[7];
      ST_AACK:  sda_nx = 1'b0;
      ST_DACK:  sda_nx = rd_q && more;
      ST_STOP:  sda_nx = (q_q != 2'd3);
      ST_RSET:  sda_nx = 1'b0;
      default:  sda_nx = 1'b0;
    endcase
  end

  // SDA only moves once SCL is already low
  assign keep_sda = (state_q != ST_IDLE) && (state_q != ST_START) && (q_q == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      scl_low_o <= scl_nx;
      if (!keep_sda) sda_low_o <= sda_nx;
    end
  end
endmodule

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = OFF_W,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tick_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              irq_o
);
  logic             start_q, int_en_q, blk_en_q, dir_q, ae_ie_q, af_ie_q, hold_q;
  logic [3:0]       ae_lvl_q, af_lvl_q;
  logic [6:0]       taddr_q;
  logic [CNT_W-1:0] count_q;
  logic             int_pend_q, nack_q;

  logic             wr_ctrl, wr_stat, start_go, flush;
  logic             tx_push, tx_pop, tx_empty, tx_full;
  logic             rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic             eng_busy, eng_done, eng_nack;
  logic             ae_hit, af_hit;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign wr_stat  = reg_we_i && (reg_addr_i == OFF_STAT);
  assign start_go = wr_ctrl && reg_wdata_i[0] && reg_wdata_i[2] && !eng_busy;
  assign flush    = reg_we_i && (reg_addr_i == OFF_FLUSH) && reg_wdata_i[0];
  assign tx_push  = reg_we_i && (reg_addr_i == OFF_TXD);
  assign rx_pop   = reg_re_i && (reg_addr_i == OFF_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      int_en_q <= 1'b0;
      blk_en_q <= 1'b0;
      dir_q    <= 1'b0;
      ae_ie_q  <= 1'b0;
      af_ie_q  <= 1'b0;
      hold_q   <= 1'b0;
      ae_lvl_q <= '0;
      af_lvl_q <= '0;
      taddr_q  <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        start_q  <= reg_wdata_i[0];
        int_en_q <= reg_wdata_i[1];
        blk_en_q <= reg_wdata_i[2];
        dir_q    <= reg_wdata_i[3];
        ae_ie_q  <= reg_wdata_i[9];
        af_ie_q  <= reg_wdata_i[10];
        ae_lvl_q <= reg_wdata_i[15:12];
        af_lvl_q <= reg_wdata_i[19:16];
        hold_q   <= reg_wdata_i[20];
      end
      if (reg_we_i && reg_addr_i == OFF_TADDR) taddr_q <= reg_wdata_i[7:1];
      if (reg_we_i && reg_addr_i == OFF_COUNT) count_q <= reg_wdata_i[CNT_W-1:0];
    end
  end

  // event set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_pend_q <= 1'b0;
      nack_q     <= 1'b0;
    end else begin
      if (eng_done)     int_pend_q <= 1'b1;
      else if (wr_stat) int_pend_q <= int_pend_q & reg_wdata_i[2];
      if (eng_nack)     nack_q <= 1'b1;
      else if (wr_stat) nack_q <= nack_q & reg_wdata_i[1];
    end
  end

  i2cm_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_push), .wdata_i(reg_wdata_i[7:0]),
    .pop_i(tx_pop), .rdata_o(tx_head),
    .level_o(tx_level), .empty_o(tx_empty), .full_o(tx_full)
  );

  i2cm_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push), .wdata_i(rx_byte),
    .pop_i(rx_pop), .rdata_o(rx_head),
    .level_o(rx_level), .empty_o(rx_empty), .full_o(rx_full)
  );

  i2cm_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni, .tick_i,
    .go_i(start_go), .rd_i(reg_wdata_i[3]), .hold_bus_i(reg_wdata_i[20]),
    .addr_i(taddr_q), .count_i(count_q),
    .tx_data_i(tx_head), .tx_avail_i(!tx_empty), .tx_pop_o(tx_pop),
    .rx_data_o(rx_byte), .rx_push_o(rx_push), .rx_space_i(!rx_full),
    .sda_i,
    .busy_o(eng_busy), .done_o(eng_done), .nack_o(eng_nack),
    .scl_low_o(scl_oe_o), .sda_low_o(sda_oe_o)
  );

  assign ae_hit = ae_ie_q && eng_busy && !dir_q && (tx_level <= LVL_W'(ae_lvl_q));
  assign af_hit = af_ie_q && (af_lvl_q != '0) && (rx_level >= LVL_W'(af_lvl_q));
  assign irq_o  = int_en_q && (int_pend_q || ae_hit || af_hit);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL: begin
        reg_rdata_o[0]     = start_q;
        reg_rdata_o[1]     = int_en_q;
        reg_rdata_o[2]     = blk_en_q;
        reg_rdata_o[3]     = dir_q;
        reg_rdata_o[9]     = ae_ie_q;
        reg_rdata_o[10]    = af_ie_q;
        reg_rdata_o[15:12] = ae_lvl_q;
        reg_rdata_o[19:16] = af_lvl_q;
        reg_rdata_o[20]    = hold_q;
      end
      OFF_TADDR: reg_rdata_o[7:0] = {taddr_q, 1'b0};
      OFF_COUNT: reg_rdata_o[CNT_W-1:0] = count_q;
      OFF_RXD:   reg_rdata_o[7:0] = rx_empty ? 8'h00 : rx_head;
      OFF_STAT: begin
        reg_rdata_o[0]  = eng_busy;
        reg_rdata_o[1]  = nack_q;
        reg_rdata_o[2]  = int_pend_q;
        reg_rdata_o[3]  = tx_empty;
        reg_rdata_o[4]  = rx_full;
        reg_rdata_o[20] = scl_i;
        reg_rdata_o[21] = sda_i;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          go_i,
  input logic          busy_i,
  input logic          done_i,
  input logic          nack_ev_i,
  input logic          int_pend_i,
  input logic          nack_flag_i,
  input logic          int_en_i,
  input logic          irq_i,
  input logic [LW-1:0] tx_level_i,
  input logic [LW-1:0] rx_level_i,
  input logic          scl_low_i,
  input logic          sda_low_i
);
  p_idle_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_low_i && !sda_low_i));

  p_busy_from_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(go_i));

  p_nack_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_ev_i |=> nack_flag_i);

  p_done_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (int_pend_i && !busy_i));

  p_irq_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i && int_pend_i) |-> irq_i);

  p_level_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(tx_level_i) <= DEPTH) && (int'(rx_level_i) <= DEPTH));
endmodule

bind i2c_fifo_master i2cm_checker #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .go_i(start_go), .busy_i(eng_busy),
  .done_i(eng_done), .nack_ev_i(eng_nack), .int_pend_i(int_pend_q),
  .nack_flag_i(nack_q), .int_en_i(int_en_q), .irq_i(irq_o),
  .tx_level_i(tx_level), .rx_level_i(rx_level),
  .scl_low_i(scl_oe_o), .sda_low_i(sda_oe_o)
);

// File: tb/i2c_fifo_master_bench.sv
module i2c_fifo_master_bench;
  import i2cm_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        scl_oe_o, sda_oe_o, irq_o, scl_line, sda_line;
  logic        slv_low = 1'b0;

  assign scl_line = !scl_oe_o;
  assign sda_line = !(sda_oe_o || slv_low);

  i2c_fifo_master u_i2c_fifo_master (
    .clk_i, .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .tick_i, .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o, .sda_oe_o, .irq_o
  );

  always #(CLK_PERIOD/2) clk_i = !clk_i;

  int checks = 0, errors = 0, cycles = 0;
  logic [1:0] tdiv = '0;
  always @(negedge clk_i) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd3);
  end

  // ---------------- behavioural target and bus monitor ----------------
  logic [7:0] addr_log[$], wr_log[$];
  int         mack_log[$];
  int         starts = 0, stops = 0, nack_at = -1;
  logic [6:0] slv_addr = 7'h50;
  logic       scl_p = 1'b1, sda_p = 1'b1, rdm = 1'b0, hit = 1'b0, rd_halt = 1'b0;
  logic [7:0] shf = '0;
  int         bitc = 0, bidx = 0;

  function automatic logic [7:0] rbyte(int k);
    logic [31:0] t;
    t = 32'h3C + k * 37;
    return t[7:0];
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (scl_line && scl_p && sda_p && !sda_line) begin
        starts++; bitc = 0; bidx = 0; slv_low = 1'b0; rd_halt = 1'b0; rdm = 1'b0; hit = 1'b0;
      end else if (scl_line && scl_p && !sda_p && sda_line) begin
        stops++; slv_low = 1'b0;
      end
      if (!scl_p && scl_line) begin
        if (bitc < 8) shf = {shf[6:0], sda_line};
        else if (rdm && hit && bidx > 0) begin
          mack_log.push_back(int'(sda_line));
          if (sda_line) rd_halt = 1'b1;
        end
        bitc++;
      end else if (scl_p && !scl_line) begin
        if (bitc == 8) begin
          if (bidx == 0) begin
            addr_log.push_back(shf);
            rdm = shf[0];
            hit = (shf[7:1] == slv_addr);
            slv_low = hit;
          end else if (!rdm) begin
            wr_log.push_back(shf);
            slv_low = hit && (bidx != nack_at);
          end else slv_low = 1'b0;
        end else if (bitc == 9) begin
          bitc = 0; bidx++;
          slv_low = rdm && hit && !rd_halt && !rbyte(bidx)[7];
        end else begin
          slv_low = rdm && hit && bidx > 0 && !rd_halt && !rbyte(bidx)[7-bitc];
        end
      end
    end
    scl_p = scl_line;
    sda_p = sda_line;
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(OFF_STAT, s);
      if (!s[0]) break;
      repeat (6) @(negedge clk_i);
    end
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk_i);
      if (irq_o) begin ok = 1; break; end
    end
  endtask

  task automatic clear_logs();
    addr_log.delete(); wr_log.delete(); mack_log.delete();
    starts = 0; stops = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      summary();
    end
  end

  localparam logic [31:0] C_GO  = 32'h7;       // start | irq enable | enable
  localparam logic [31:0] C_RD  = 32'h8;
  localparam logic [31:0] C_HLD = 32'h10_0000;

  initial begin
    logic [31:0] s, d;
    bit ok;
    int n, mism;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 bus", {scl_oe_o, sda_oe_o}, 0);
    rd(OFF_STAT, s);
    chk("R1 status", s[4:0], 5'h08);

    wr(OFF_TADDR, 32'hA0);

    // R3 basic write
    clear_logs();
    wr(OFF_TXD, 32'h11); wr(OFF_TXD, 32'h22); wr(OFF_TXD, 32'h33);
    wr(OFF_COUNT, 3);
    wr(OFF_CTRL, C_GO);
    wait_idle();
    chk("R2 write addr", addr_log.size() > 0 ? addr_log[0] : 0, 8'hA0);
    chk("R3 count", wr_log.size(), 3);
    chk("R3 bytes", wr_log.size() == 3 ? {wr_log[0], wr_log[1], wr_log[2]} : 0, 24'h112233);
    chk("R5 stop", stops, 1);
    rd(OFF_STAT, s);
    chk("R7 status", s[2:0], 3'b100);
    chk("R7 irq", irq_o, 1);

    // R8 status clear
    wr(OFF_STAT, 32'h6);
    rd(OFF_STAT, s);
    chk("R8 keep on 1", s[2], 1);
    wr(OFF_STAT, 32'h0);
    rd(OFF_STAT, s);
    chk("R8 clear on 0", s[2], 0);
    chk("R8 irq low", irq_o, 0);

    // R4 basic read
    clear_logs();
    wr(OFF_COUNT, 4);
    wr(OFF_CTRL, C_GO | C_RD);
    wait_idle();
    chk("R2 read addr", addr_log.size() > 0 ? addr_log[0] : 0, 8'hA1);
    mism = 0;
    for (int i = 1; i <= 4; i++) begin
      rd(OFF_RXD, d);
      if (d[7:0] != rbyte(i)) mism++;
    end
    chk("R4 rx data", mism, 0);
    chk("R4 ack pattern", mack_log.size() == 4 ?
        {mack_log[0][0], mack_log[1][0], mack_log[2][0], mack_log[3][0]} : 4'hF, 4'b0001);
    wr(OFF_STAT, 0);

    // R5 repeated start
    clear_logs();
    wr(OFF_TXD, 32'hA5); wr(OFF_TXD, 32'h5A);
    wr(OFF_COUNT, 2);
    wr(OFF_CTRL, C_GO | C_HLD);
    wait_idle();
    chk("R5 no stop", stops, 0);
    chk("R5 released", {scl_oe_o, sda_oe_o}, 0);
    wr(OFF_CTRL, C_GO | C_RD);
    wait_idle();
    chk("R5 restart count", starts, 2);
    chk("R5 final stop", stops, 1);
    rd(OFF_RXD, d);
    chk("R5 read after restart", d[7:0], rbyte(1));
    rd(OFF_RXD, d);
    wr(OFF_STAT, 0);

    // R6 address NACK
    clear_logs();
    wr(OFF_TADDR, 32'hA4);
    wr(OFF_TXD, 32'h01); wr(OFF_TXD, 32'h02);
    wr(OFF_COUNT, 2);
    wr(OFF_CTRL, C_GO);
    wait_idle();
    rd(OFF_STAT, s);
    chk("R6 addr nack flag", s[1], 1);
    chk("R6 no data", wr_log.size(), 0);
    chk("R6 stop", stops, 1);
    wr(OFF_FLUSH, 1);
    wr(OFF_STAT, 0);
    wr(OFF_TADDR, 32'hA0);

    // R6 data NACK and R10 flush
    clear_logs();
    nack_at = 2;
    for (int i = 0; i < 4; i++) wr(OFF_TXD, 32'h80 + i);
    wr(OFF_COUNT, 4);
    wr(OFF_CTRL, C_GO);
    wait_idle();
    nack_at = -1;
    rd(OFF_STAT, s);
    chk("R6 data nack flag", s[1], 1);
    chk("R6 bytes sent", wr_log.size(), 2);
    chk("R10 leftover", s[3], 0);
    wr(OFF_FLUSH, 1);
    rd(OFF_STAT, s);
    chk("R10 flushed", s[3], 1);
    wr(OFF_STAT, 0);

    // R9 almost-empty refill
    clear_logs();
    for (int i = 0; i < 16; i++) wr(OFF_TXD, 32'h40 + i);
    wr(OFF_COUNT, 24);
    wr(OFF_CTRL, C_GO | 32'h200 | (32'h4 << 12));
    n = 16;
    mism = 0;
    while (n < 24) begin
      wait_irq(ok);
      if (!ok) break;
      mism++;
      for (int k = 0; k < 4 && n < 24; k++) begin
        wr(OFF_TXD, 32'h40 + n); n++;
      end
    end
    wait_idle();
    chk("R9 refill irq seen", mism > 0, 1);
    chk("R9 write total", wr_log.size(), 24);
    n = 0;
    foreach (wr_log[i]) if (wr_log[i] != 8'(8'h40 + i)) n++;
    chk("R9 write order", n, 0);
    wr(OFF_STAT, 0);

    // R9 almost-full drain
    clear_logs();
    wr(OFF_COUNT, 20);
    wr(OFF_CTRL, C_GO | C_RD | 32'h400 | (32'hC << 16));
    wait_irq(ok);
    rd(OFF_STAT, s);
    chk("R9 full irq while busy", {ok, s[0]}, 2'b11);
    mism = 0;
    for (int i = 1; i <= 12; i++) begin
      rd(OFF_RXD, d); if (d[7:0] != rbyte(i)) mism++;
    end
    wait_idle();
    for (int i = 13; i <= 20; i++) begin
      rd(OFF_RXD, d); if (d[7:0] != rbyte(i)) mism++;
    end
    chk("R9 read data", mism, 0);
    wr(OFF_STAT, 0);

    // R12 receive FIFO full stall
    clear_logs();
    wr(OFF_COUNT, 18);
    wr(OFF_CTRL, C_GO | C_RD);
    repeat (4000) @(negedge clk_i);
    rd(OFF_STAT, s);
    chk("R12 held busy", s[0], 1);
    chk("R12 rx full", s[4], 1);
    mism = 0;
    for (int i = 1; i <= 16; i++) begin
      rd(OFF_RXD, d); if (d[7:0] != rbyte(i)) mism++;
    end
    wait_idle();
    for (int i = 17; i <= 18; i++) begin
      rd(OFF_RXD, d); if (d[7:0] != rbyte(i)) mism++;
    end
    chk("R12 no loss", mism, 0);
    wr(OFF_STAT, 0);

    // R11 transmit underflow wait
    clear_logs();
    wr(OFF_TXD, 32'hC1);
    wr(OFF_COUNT, 3);
    wr(OFF_CTRL, C_GO);
    repeat (2000) @(negedge clk_i);
    rd(OFF_STAT, s);
    chk("R11 waiting busy", s[0], 1);
    chk("R11 one byte out", wr_log.size(), 1);
    wr(OFF_TXD, 32'hC2); wr(OFF_TXD, 32'hC3);
    wait_idle();
    chk("R11 resumed", wr_log.size() == 3 ? {wr_log[0], wr_log[1], wr_log[2]} : 0, 24'hC1C2C3);
    wr(OFF_STAT, 0);

    // R2 start ignored while busy / disabled
    clear_logs();
    wr(OFF_TXD, 32'h01); wr(OFF_TXD, 32'h02);
    wr(OFF_COUNT, 2);
    wr(OFF_CTRL, C_GO);
    repeat (60) @(negedge clk_i);
    wr(OFF_CTRL, C_GO);
    wait_idle();
    repeat (100) @(negedge clk_i);
    chk("R2 busy start ignored", starts, 1);
    wr(OFF_CTRL, 32'h3);
    repeat (200) @(negedge clk_i);
    rd(OFF_STAT, s);
    chk("R2 disabled ignored", {s[0], 8'(starts)}, 9'd1);
    wr(OFF_STAT, 0);

    // R13 zero count
    clear_logs();
    wr(OFF_COUNT, 0);
    wr(OFF_CTRL, C_GO);
    wait_idle();
    chk("R13 address only", {8'(addr_log.size()), 8'(wr_log.size()), 8'(stops)}, 24'h010001);

    summary();
  end
endmodule